// File: doc/BRIEF.md
# Asynchronous Serial Port with Software Flow Control

This block is a full-duplex serial port with two wires: `txd` carries frames out and `rxd` brings frames in. There are no hardware handshake lines. A host hands it one byte at a time through a valid/ready pair. It receives bytes as one-cycle strobes that carry a parity-error flag and a framing-error flag. Runtime control inputs set four things:
- the bit-rate divisor;
- whether a parity bit is present, and if so whether it is even or odd;
- one or two stop bits;
- software flow control.

Bit timing uses 16 ticks per bit. Each lane has its own tick counter that fires once every `cfg_div` clocks. With a 4.9152 MHz clock, a divisor of 8 gives 38,400 bit/s and 1024 gives 300 bit/s. When flow control is on, an error-free received 0x13 (XOFF) halts the transmitter and an error-free 0x11 (XON) resumes it. Neither of these two bytes reaches the host. A byte already on the wire always finishes. The halt only blocks acceptance of the next byte.

Transmitter states are TX_IDLE, TX_START, TX_DATA, TX_PARITY, TX_STOP1 and TX_STOP2.
- TX_IDLE moves to TX_START when a byte is accepted.
- After 16 ticks, TX_START moves to TX_DATA.
- After 16 ticks on the last bit, TX_DATA moves to TX_PARITY when parity is enabled, otherwise to TX_STOP1.
- TX_PARITY moves to TX_STOP1.
- TX_STOP1 moves to TX_STOP2 when two stop bits are selected, otherwise to TX_IDLE.
- TX_STOP2 moves to TX_IDLE.

Receiver states are RX_IDLE, RX_START, RX_DATA, RX_PARITY and RX_STOP.
- A synchronised falling edge moves RX_IDLE to RX_START.
- At the 8th tick RX_START goes to RX_DATA if the line is still low, or back to RX_IDLE if it is high.
- RX_DATA moves to RX_PARITY or RX_STOP after the 8th data bit.
- RX_PARITY moves to RX_STOP.
- RX_STOP delivers the byte at mid-bit and returns to RX_IDLE.

The flow filter has two states, FLOW_RUN and FLOW_HALT.
- An error-free XOFF moves it from FLOW_RUN to FLOW_HALT.
- An error-free XON moves it back.
- When flow control is off, it is forced to FLOW_RUN.

Top module: `serial_port_xflow`

## Requirements
- R1: Every transmitted bit lasts 16×`cfg_div` clock cycles. A `cfg_div` of 0 behaves as 1. A frame of N bits therefore holds `tx_ready` low for exactly 16×N×`cfg_div` cycles after acceptance. The receiver decodes frames sent at the same bit time.
- R2: `txd` idles high. A frame is a low start bit, then 8 data bits least-significant first, then the optional parity bit, then high stop bit(s).
- R3: A parity bit follows the data only when `cfg_par_en` is 1. Without it the frame is 10 bits long (one stop bit).
- R4: With `cfg_par_odd`=0 the parity bit is the XOR of the 8 data bits (even parity). With `cfg_par_odd`=1 it is the inverse (odd parity).
- R5: `cfg_two_stop`=1 sends two high stop bits. `cfg_two_stop`=0 sends one.
- R6: A correctly framed incoming byte is presented on `rx_data` with `rx_valid` high for exactly one cycle and both error flags low.
- R7: When parity is enabled and the received parity bit mismatches, `rx_par_err` is high during that byte's `rx_valid`.
- R8: When the first stop bit samples low, `rx_frm_err` is high during that byte's `rx_valid`.
- R9: With `cfg_xflow`=1:
  - An error-free received 0x13 gives no `rx_valid`. It raises `tx_paused` and holds `tx_ready` low, and `txd` stays high while the host waits.
  - An error-free received 0x11 gives no `rx_valid`. It clears the halt, and the waiting byte is sent.
- R10: An XOFF that arrives while a byte is being shifted out lets that byte finish intact, stop bits included. The halt applies from the next byte.
- R11: With `cfg_xflow`=0:
  - 0x11 and 0x13 are delivered as ordinary data and never pause the transmitter.
  - Clearing `cfg_xflow` while halted drops `tx_paused` and restores `tx_ready` on the next cycle.
- R12: After reset `txd`=1, `tx_ready`=1, `rx_valid`=0 and `tx_paused`=0.
- R13: A low pulse on `rxd` shorter than half a bit is rejected at the mid-start check. No byte is delivered, and the next real frame is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_div | input | DIV_W | Clocks per oversampling tick (0 acts as 1) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| cfg_two_stop | input | 1 | 1 selects two transmitted stop bits |
| cfg_xflow | input | 1 | Software flow control enable |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Host offers `tx_data` |
| tx_ready | output | 1 | Transmitter idle and not halted; byte taken when both high |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line (asynchronous) |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| rx_par_err | output | 1 | Parity mismatch on the strobed byte |
| rx_frm_err | output | 1 | Low first stop bit on the strobed byte |
| tx_paused | output | 1 | Transmitter halted by a received XOFF |

## Verification
A transmitter state stuck or skipped shows up as a wrong bit or a missing stop on `txd` within one bit time (16×`cfg_div` cycles). A bad bit count shows up as a `tx_ready` low interval of the wrong length at the end of the frame. A receiver state error, such as a miscounted tick or a lost mid-start check, corrupts `rx_data` or its flags at the next strobe, or makes the strobe vanish, roughly ten bit times after the start edge. A wrong flow-filter state appears two cycles after the control byte's stop mid-point, as `tx_paused` or `tx_ready` disagreeing with the last XON/XOFF seen, or as a control byte leaking onto `rx_valid`.

// File: rtl/sxp_pkg.sv
package sxp_pkg;

    localparam int CHAR_W    = 8;
    localparam int OVS       = 16;
    localparam int OVS_W     = $clog2(OVS);
    localparam int BIT_IDX_W = $clog2(CHAR_W);
    localparam int MID_TICK  = OVS / 2 - 1;

    localparam logic [CHAR_W-1:0] XON_CODE  = 8'h11;
    localparam logic [CHAR_W-1:0] XOFF_CODE = 8'h13;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PARITY,
        TX_STOP1,
        TX_STOP2
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP
    } rx_state_e;

    typedef enum logic {
        FLOW_RUN,
        FLOW_HALT
    } flow_state_e;

    typedef struct packed {
        logic par_en;
        logic par_odd;
        logic two_stop;
    } frame_cfg_t;

endpackage

// File: rtl/sxp_baud.sv
module sxp_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] reload;

    always_comb begin
        reload = (div == '0) ? '0 : div - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= reload;
        end else if (cnt == '0) begin
            cnt <= reload;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    always_comb begin
        tick = !clr && (cnt == '0);
    end

endmodule

// File: rtl/sxp_tx.sv
module sxp_tx
    import sxp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              hold,
    input  frame_cfg_t        cfg,
    input  logic [CHAR_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              accept,
    output logic              txd
);

    tx_state_e             st, st_n;
    logic [OVS_W-1:0]      sub;
    logic [BIT_IDX_W-1:0]  idx;
    logic [CHAR_W-1:0]     sh;
    logic                  par_en_q;
    logic                  two_stop_q;
    logic                  pbit;
    logic                  bit_end;

    always_comb begin
        bit_end = tick && (sub == OVS_W'(OVS - 1));
    end

    // next-state
    always_comb begin
        st_n = st;
        unique case (st)
            TX_IDLE:   if (accept)  st_n = TX_START;
            TX_START:  if (bit_end) st_n = TX_DATA;
            TX_DATA:   if (bit_end && idx == BIT_IDX_W'(CHAR_W - 1))
                           st_n = par_en_q ? TX_PARITY : TX_STOP1;
            TX_PARITY: if (bit_end) st_n = TX_STOP1;
            TX_STOP1:  if (bit_end) st_n = two_stop_q ? TX_STOP2 : TX_IDLE;
            TX_STOP2:  if (bit_end) st_n = TX_IDLE;
            default:   st_n = TX_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= TX_IDLE;
            sub        <= '0;
            idx        <= '0;
            sh         <= '0;
            par_en_q   <= 1'b0;
            two_stop_q <= 1'b0;
            pbit       <= 1'b0;
        end else begin
            st <= st_n;
            if (accept) begin
                sh         <= in_data;
                par_en_q   <= cfg.par_en;
                two_stop_q <= cfg.two_stop;
                pbit       <= (^in_data) ^ cfg.par_odd;
                sub        <= '0;
                idx        <= '0;
            end else if (st != TX_IDLE && tick) begin
                sub <= sub + 1'b1;
                if (bit_end && st == TX_DATA) begin
                    sh  <= sh >> 1;
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        in_ready = (st == TX_IDLE) && !hold;
        accept   = in_ready && in_valid;
        unique case (st)
            TX_IDLE:   txd = 1'b1;
            TX_START:  txd = 1'b0;
            TX_DATA:   txd = sh[0];
            TX_PARITY: txd = pbit;
            TX_STOP1:  txd = 1'b1;
            TX_STOP2:  txd = 1'b1;
            default:   txd = 1'b1;
        endcase
    end

endmodule

// File: rtl/sxp_rx.sv
module sxp_rx
    import sxp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic              tick,
    input  logic              par_en,
    input  logic              par_odd,
    output logic              start_det,
    output logic              done,
    output logic [CHAR_W-1:0] data,
    output logic              par_err,
    output logic              frm_err
);

    rx_state_e             st, st_n;
    logic [2:0]            sy;
    logic                  line;
    logic                  fall;
    logic [OVS_W-1:0]      sub;
    logic [BIT_IDX_W-1:0]  idx;
    logic [CHAR_W-1:0]     sh;
    logic                  pbad;
    logic                  mid_start;
    logic                  bit_end;
    logic                  done_q;
    logic [CHAR_W-1:0]     data_q;
    logic                  pe_q;
    logic                  fe_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sy <= '1;
        else        sy <= {sy[1:0], rxd};
    end

    always_comb begin
        line      = sy[1];
        fall      = sy[2] && !sy[1];
        mid_start = tick && (sub == OVS_W'(MID_TICK));
        bit_end   = tick && (sub == OVS_W'(OVS - 1));
    end

    // next-state
    always_comb begin
        st_n = st;
        unique case (st)
            RX_IDLE:   if (fall)      st_n = RX_START;
            RX_START:  if (mid_start) st_n = line ? RX_IDLE : RX_DATA;
            RX_DATA:   if (bit_end && idx == BIT_IDX_W'(CHAR_W - 1))
                           st_n = par_en ? RX_PARITY : RX_STOP;
            RX_PARITY: if (bit_end)   st_n = RX_STOP;
            RX_STOP:   if (bit_end)   st_n = RX_IDLE;
            default:   st_n = RX_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= RX_IDLE;
            sub    <= '0;
            idx    <= '0;
            sh     <= '0;
            pbad   <= 1'b0;
            done_q <= 1'b0;
            data_q <= '0;
            pe_q   <= 1'b0;
            fe_q   <= 1'b0;
        end else begin
            st     <= st_n;
            done_q <= 1'b0;
            if (st == RX_IDLE) begin
                sub  <= '0;
                idx  <= '0;
                pbad <= 1'b0;
            end else if (tick) begin
                if (mid_start && st == RX_START) sub <= '0;
                else                             sub <= sub + 1'b1;
                if (bit_end) begin
                    unique case (st)
                        RX_DATA: begin
                            sh  <= {line, sh[CHAR_W-1:1]};
                            idx <= idx + 1'b1;
                        end
                        RX_PARITY: pbad <= ((^sh) ^ par_odd) != line;
                        RX_STOP: begin
                            done_q <= 1'b1;
                            data_q <= sh;
                            pe_q   <= pbad;
                            fe_q   <= !line;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // outputs
    always_comb begin
        start_det = (st == RX_IDLE) && fall;
        done      = done_q;
        data      = data_q;
        par_err   = pe_q;
        frm_err   = fe_q;
    end

endmodule

// File: rtl/sxp_flow.sv
module sxp_flow
    import sxp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              done,
    input  logic [CHAR_W-1:0] data,
    input  logic              par_err,
    input  logic              frm_err,
    output logic              paused,
    output logic              out_valid,
    output logic [CHAR_W-1:0] out_data,
    output logic              out_par_err,
    output logic              out_frm_err
);

    flow_state_e st, st_n;
    logic        clean;
    logic        is_ctl;
    logic        v_q, pe_q, fe_q;
    logic [CHAR_W-1:0] d_q;

    always_comb begin
        clean  = !par_err && !frm_err;
        is_ctl = en && done && clean && (data == XON_CODE || data == XOFF_CODE);
    end

    // next-state
    always_comb begin
        st_n = st;
        unique case (st)
            FLOW_RUN:  if (is_ctl && data == XOFF_CODE) st_n = FLOW_HALT;
            FLOW_HALT: if (is_ctl && data == XON_CODE)  st_n = FLOW_RUN;
            default:   st_n = FLOW_RUN;
        endcase
        if (!en) st_n = FLOW_RUN;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= FLOW_RUN;
            v_q  <= 1'b0;
            pe_q <= 1'b0;
            fe_q <= 1'b0;
            d_q  <= '0;
        end else begin
            st   <= st_n;
            v_q  <= done && !is_ctl;
            pe_q <= done && !is_ctl && par_err;
            fe_q <= done && !is_ctl && frm_err;
            if (done) d_q <= data;
        end
    end

    // outputs
    always_comb begin
        paused      = (st == FLOW_HALT);
        out_valid   = v_q;
        out_data    = d_q;
        out_par_err = pe_q;
        out_frm_err = fe_q;
    end

endmodule

// File: rtl/serial_port_xflow.sv
module serial_port_xflow
    import sxp_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_par_en,
    input  logic             cfg_par_odd,
    input  logic             cfg_two_stop,
    input  logic             cfg_xflow,
    input  logic [7:0]       tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    output logic             txd,
    input  logic             rxd,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    output logic             rx_par_err,
    output logic             rx_frm_err,
    output logic             tx_paused
);

    localparam int LANES   = 2;
    localparam int TX_LANE = 0;
    localparam int RX_LANE = 1;

    logic [LANES-1:0] lane_clr;
    logic [LANES-1:0] lane_tick;
    frame_cfg_t       fcfg;
    logic             tx_accept;
    logic             rx_start;
    logic             rx_done;
    logic [CHAR_W-1:0] rx_raw;
    logic             rx_pe_raw;
    logic             rx_fe_raw;
    logic             halt;

    always_comb begin
        fcfg.par_en   = cfg_par_en;
        fcfg.par_odd  = cfg_par_odd;
        fcfg.two_stop = cfg_two_stop;
        lane_clr[TX_LANE] = tx_accept;
        lane_clr[RX_LANE] = rx_start;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sxp_baud #(.DIV_W(DIV_W)) u_baud (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (lane_clr[g]),
            .div   (cfg_div),
            .tick  (lane_tick[g])
        );
    end

    sxp_tx u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (lane_tick[TX_LANE]),
        .hold     (halt),
        .cfg      (fcfg),
        .in_data  (tx_data),
        .in_valid (tx_valid),
        .in_ready (tx_ready),
        .accept   (tx_accept),
        .txd      (txd)
    );

    sxp_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rxd       (rxd),
        .tick      (lane_tick[RX_LANE]),
        .par_en    (cfg_par_en),
        .par_odd   (cfg_par_odd),
        .start_det (rx_start),
        .done      (rx_done),
        .data      (rx_raw),
        .par_err   (rx_pe_raw),
        .frm_err   (rx_fe_raw)
    );

    sxp_flow u_flow (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (cfg_xflow),
        .done        (rx_done),
        .data        (rx_raw),
        .par_err     (rx_pe_raw),
        .frm_err     (rx_fe_raw),
        .paused      (halt),
        .out_valid   (rx_valid),
        .out_data    (rx_data),
        .out_par_err (rx_par_err),
        .out_frm_err (rx_frm_err)
    );

    always_comb begin
        tx_paused = halt;
    end

endmodule

// File: rtl/serial_port_xflow_chk.sv
module serial_port_xflow_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_xflow,
    input logic       tx_ready,
    input logic       txd,
    input logic [7:0] rx_data,
    input logic       rx_valid,
    input logic       rx_par_err,
    input logic       rx_frm_err,
    input logic       tx_paused
);

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> txd); // R2

    AST_HALT_BLOCKS_TX: assert property (@(posedge clk) disable iff (!rst_n)
        tx_paused |-> !tx_ready); // R9

    AST_ERR_ONLY_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_par_err || rx_frm_err) |-> rx_valid); // R7

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R6

    AST_NOFLOW_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_xflow |=> !tx_paused); // R11

    AST_CTRL_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_par_err && !rx_frm_err && $past(cfg_xflow))
        |-> (rx_data != 8'h11 && rx_data != 8'h13)); // R9

endmodule

bind serial_port_xflow serial_port_xflow_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_xflow  (cfg_xflow),
    .tx_ready   (tx_ready),
    .txd        (txd),
    .rx_data    (rx_data),
    .rx_valid   (rx_valid),
    .rx_par_err (rx_par_err),
    .rx_frm_err (rx_frm_err),
    .tx_paused  (tx_paused)
);

// File: tb/sim_serial_port_xflow.sv
`timescale 1ns/1ps
module sim_serial_port_xflow;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_div = 16'd1;
    logic        cfg_par_en = 1'b0;
    logic        cfg_par_odd = 1'b0;
    logic        cfg_two_stop = 1'b0;
    logic        cfg_xflow = 1'b0;
    logic [7:0]  tx_data = 8'h00;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic        txd;
    logic        rxd = 1'b1;
    logic [7:0]  rx_data;
    logic        rx_valid;
    logic        rx_par_err;
    logic        rx_frm_err;
    logic        tx_paused;

    int checks = 0;
    int failures = 0;
    int mon_cnt = 0;
    logic [7:0] mon_data = 8'h00;
    logic mon_pe = 1'b0;
    logic mon_fe = 1'b0;

    always #4 clk = ~clk;

    serial_port_xflow u0 (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop), .cfg_xflow(cfg_xflow),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
        .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid), .rx_par_err(rx_par_err),
        .rx_frm_err(rx_frm_err), .tx_paused(tx_paused)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            mon_cnt  = mon_cnt + 1;
            mon_data = rx_data;
            mon_pe   = rx_par_err;
            mon_fe   = rx_frm_err;
        end
    end

    // vector: {data, par_en, par_odd, two_stop}
    localparam int NVEC = 6;
    localparam logic [10:0] VEC [NVEC] = '{
        {8'h00, 1'b0, 1'b0, 1'b0},
        {8'hFF, 1'b1, 1'b0, 1'b0},
        {8'h5A, 1'b1, 1'b1, 1'b0},
        {8'h81, 1'b0, 1'b0, 1'b1},
        {8'h3C, 1'b1, 1'b1, 1'b1},
        {8'h11, 1'b1, 1'b0, 1'b1}
    };

    function automatic int bitc();
        return 16 * ((cfg_div == 16'd0) ? 1 : int'(cfg_div));
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tx_send(input logic [7:0] d);
        while (!tx_ready) @(negedge clk);
        tx_data  = d;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic capture_tx(input bit pe, input bit ts,
                              output logic [7:0] d, output logic p, output logic sok);
        int bc;
        bc = bitc();
        while (txd !== 1'b0) @(negedge clk);
        repeat (bc / 2) @(negedge clk);
        sok = (txd == 1'b0);
        for (int i = 0; i < 8; i++) begin
            repeat (bc) @(negedge clk);
            d[i] = txd;
        end
        p = 1'b0;
        if (pe) begin
            repeat (bc) @(negedge clk);
            p = txd;
        end
        repeat (bc) @(negedge clk);
        sok = sok && txd;
        if (ts) begin
            repeat (bc) @(negedge clk);
            sok = sok && txd;
        end
    endtask

    task automatic send_rx(input logic [7:0] d, input bit pe, input bit odd,
                           input bit bad_par, input bit bad_stop);
        int bc;
        bc = bitc();
        rxd = 1'b0;
        repeat (bc) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            repeat (bc) @(negedge clk);
        end
        if (pe) begin
            rxd = (^d) ^ odd ^ bad_par;
            repeat (bc) @(negedge clk);
        end
        rxd = !bad_stop;
        repeat (bc) @(negedge clk);
        rxd = 1'b1;
        repeat (bc) @(negedge clk);
    endtask

    task automatic measure_frame(input logic [7:0] d, input int exp, input string req);
        int n;
        tx_send(d);
        n = 0;
        while (!tx_ready && n < 100000) begin
            n++;
            @(negedge clk);
        end
        chk(req, n, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic p, sok;
        int base;
        int hi_cnt;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 txd", txd, 1);
        chk("R12 tx_ready", tx_ready, 1);
        chk("R12 rx_valid", rx_valid, 0);
        chk("R12 tx_paused", tx_paused, 0);

        // vector table: R2 R3 R4 R5 R6
        for (int i = 0; i < NVEC; i++) begin
            logic [7:0] vd;
            vd           = VEC[i][10:3];
            cfg_par_en   = VEC[i][2];
            cfg_par_odd  = VEC[i][1];
            cfg_two_stop = VEC[i][0];
            fork
                tx_send(vd);
                capture_tx(VEC[i][2], VEC[i][0], d, p, sok);
            join
            chk("R2 tx data lsb first", d, vd);
            chk("R5 start/stop levels", sok, 1);
            if (VEC[i][2]) chk("R4 parity bit", p, (^vd) ^ VEC[i][1]);
            repeat (40) @(negedge clk);
            base = mon_cnt;
            send_rx(vd, VEC[i][2], VEC[i][1], 1'b0, 1'b0);
            chk("R6 rx strobe count", mon_cnt - base, 1);
            chk("R6 rx data", mon_data, vd);
            chk("R6 rx flags clear", {mon_pe, mon_fe}, 0);
        end

        // R1 / R3 / R5 frame lengths
        cfg_div = 16'd1; cfg_par_en = 0; cfg_two_stop = 0;
        measure_frame(8'hA5, 16 * 10, "R3 10-bit frame length");
        cfg_div = 16'd2; cfg_par_en = 1; cfg_two_stop = 1;
        measure_frame(8'h3E, 16 * 12 * 2, "R1 div2 two-stop length R5");
        cfg_div = 16'd0; cfg_par_en = 1; cfg_two_stop = 0;
        measure_frame(8'h01, 16 * 11, "R1 div0 acts as 1");
        cfg_div = 16'd2; cfg_par_en = 0;
        repeat (20) @(negedge clk);
        base = mon_cnt;
        send_rx(8'h96, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R1 rx at div2 count", mon_cnt - base, 1);
        chk("R1 rx at div2 data", mon_data, 8'h96);
        cfg_div = 16'd1;

        // R7 parity error
        cfg_par_en = 1; cfg_par_odd = 0;
        base = mon_cnt;
        send_rx(8'h4B, 1'b1, 1'b0, 1'b1, 1'b0);
        chk("R7 strobe", mon_cnt - base, 1);
        chk("R7 par_err", mon_pe, 1);
        chk("R7 frm clean", mon_fe, 0);

        // R8 framing error
        cfg_par_en = 0;
        base = mon_cnt;
        send_rx(8'hC2, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R8 strobe", mon_cnt - base, 1);
        chk("R8 frm_err", mon_fe, 1);
        chk("R8 data", mon_data, 8'hC2);

        // R13 glitch rejection
        base = mon_cnt;
        rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (300) @(negedge clk);
        chk("R13 glitch no strobe", mon_cnt - base, 0);
        send_rx(8'h6D, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R13 next frame count", mon_cnt - base, 1);
        chk("R13 next frame data", mon_data, 8'h6D);

        // R11 flow off: control codes delivered, no pause
        cfg_xflow = 0;
        base = mon_cnt;
        send_rx(8'h13, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R11 XOFF delivered", mon_cnt - base, 1);
        chk("R11 XOFF data", mon_data, 8'h13);
        chk("R11 no pause", tx_paused, 0);
        chk("R11 ready", tx_ready, 1);

        // R10 XOFF during a byte in flight
        cfg_xflow = 1; cfg_two_stop = 1; cfg_par_en = 0;
        base = mon_cnt;
        fork
            tx_send(8'hC3);
            capture_tx(1'b0, 1'b1, d, p, sok);
            begin
                @(negedge clk);
                send_rx(8'h13, 1'b0, 1'b0, 1'b0, 1'b0);
            end
        join
        chk("R10 in-flight byte intact", d, 8'hC3);
        chk("R10 in-flight stops", sok, 1);
        chk("R9 XOFF consumed", mon_cnt - base, 0);
        chk("R9 paused", tx_paused, 1);
        repeat (40) @(negedge clk);
        chk("R10 next byte held", tx_ready, 0);

        // R9 held byte does not go out until XON
        tx_data  = 8'h77;
        tx_valid = 1'b1;
        hi_cnt = 0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (txd) hi_cnt++;
        end
        chk("R9 txd idle while halted", hi_cnt, 100);
        fork
            capture_tx(1'b0, 1'b1, d, p, sok);
            send_rx(8'h11, 1'b0, 1'b0, 1'b0, 1'b0);
            begin
                while (!tx_ready) @(negedge clk);
                @(negedge clk);
                tx_valid = 1'b0;
            end
        join
        chk("R9 XON resumes byte", d, 8'h77);
        chk("R9 XON consumed", mon_cnt - base, 0);
        chk("R9 unpaused", tx_paused, 0);

        // R11 clearing flow control releases a halt
        repeat (200) @(negedge clk);
        send_rx(8'h13, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R9 halt again", tx_paused, 1);
        cfg_xflow = 0;
        @(negedge clk);
        @(negedge clk);
        chk("R11 release pause", tx_paused, 0);
        chk("R11 release ready", tx_ready, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule